// File: doc/BRIEF.md
# SMBus Register Slave with Alert Response

This block is a byte-oriented two-wire serial slave that runs entirely in the system clock domain. Both bus lines pass through a two-flop synchroniser. The slave then finds START and STOP conditions and the SCL edges itself. It holds eight 8-bit registers, which a bus master reaches with the four simple SMBus transactions: byte write, byte read, word write and word read. A command byte sets the register pointer, and a later read returns the register at that pointer.

The 7-bit slave address has its top two bits fixed at binary 10. Three ternary strap inputs supply the lower five bits, so 27 addresses are possible. The slave also answers a broadcast write address, which a bit in register 0 can turn off. It also answers the Alert Response Address. While the slave is pulling the ALERT line low, a master can read this address to learn which device raised the alert. The slave sends its own address bitwise and takes part in wired-AND arbitration. It releases ALERT only if its whole address byte reaches the bus unharmed. SDA is driven only as an open-drain pull-down enable.

Top module: `smbus_alert_slave`

## Requirements
- R1: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START at any point, including inside a byte, drops the transfer in progress and restarts address reception. A partly received data byte is not written.
- R2: The own address is {2'b10, 9*c2 + 3*c1 + c0}, where c0, c1 and c2 are the strap codes on strap0, strap1 and strap2. Code 0 means low, 1 means open, 2 means high, and code 3 counts as high. Bytes travel MSB first, with R/W in bit 0 of the address byte. After each byte it accepts, the slave pulls SDA low during the ninth clock.
- R3: A write is address with R/W=0, then a command byte, then a data byte. Bits [2:0] of the command byte load the register pointer and bits [7:3] are ignored. The data byte is stored in the register at the pointer, and each of the three bytes is acknowledged.
- R4: After a command byte and a repeated START, an own-address read returns the register at the pointer, MSB first. The slave releases SDA during the ninth clock of every byte it sends.
- R5: If the master acknowledges a data byte it has read, the same register value is sent again (word read). After a master NACK the slave leaves SDA released until the next START or STOP, so further clocks read all ones.
- R6: In a write, every byte after the first data byte is acknowledged and discarded.
- R7: After reset, register 0 holds 0x10 and all other registers hold 0x00. Bit 4 of register 0 enables the broadcast write address 7'b1011111. While that bit is 1, writes to the broadcast address are acknowledged and stored like own-address writes. While it is 0 they are not acknowledged and change nothing. A read to the broadcast address is never acknowledged.
- R8: A read (R/W=1) to 7'b0001100 is acknowledged only while alert_pull is high. The slave then sends {own address, 1'b1} and clears alert_pull at the end of that byte. The same address with R/W=0 is not acknowledged.
- R9: A rising edge of alert_req sets alert_pull. If, while sending the alert-response byte, the slave releases SDA but samples it low, it stops driving for the rest of the transfer and keeps alert_pull set.
- R10: sda_pull changes only while the synchronised SCL is low. Addresses other than the own, broadcast and alert-response addresses are not acknowledged, and the registers do not change.
- R11: During and right after reset, sda_pull and alert_pull are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL bus level |
| sda_in | input | 1 | Raw SDA bus level |
| sda_pull | output | 1 | When high, SDA is pulled low |
| strap0 | input | 2 | Strap code for address digit of weight 1 |
| strap1 | input | 2 | Strap code for address digit of weight 3 |
| strap2 | input | 2 | Strap code for address digit of weight 9 |
| alert_req | input | 1 | Internal alert request, rising-edge sensitive |
| alert_pull | output | 1 | When high, the ALERT line is pulled low |

## Verification
The assertions take a well-behaved master for granted. It moves SDA only while SCL is low, except when it makes START and STOP, and it keeps each SCL phase much longer than the synchroniser delay. Under that assumption the slave's own SDA changes always fall in a low SCL phase. The straps are assumed to be steady during a transfer. The bench master waits two clocks after each SCL fall before it changes SDA. It changes the straps only while the bus is idle. It models a competing alert source by driving SDA low on bits where the slave has released the line.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  localparam logic [1:0]        ADDR_TOP  = 2'b10;
  localparam logic [ADDR_W-1:0] MASS_ADDR = 7'b1011111;
  localparam logic [ADDR_W-1:0] ARA_ADDR  = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } bus_st_t;

  typedef enum logic [1:0] {
    RK_ADDR,
    RK_CMD,
    RK_DATA,
    RK_SPILL
  } rx_kind_t;

  // Strap code to ternary digit: 0 low, 1 open, 2 high, 3 taken as high
  function automatic logic [4:0] strap_digit(input logic [1:0] code);
    return (code == 2'd3) ? 5'd2 : {3'b000, code};
  endfunction

endpackage

// File: rtl/smb_sync_edge.sv
module smb_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_strap_addr.sv
module smb_strap_addr
  import smb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        code0,
  input  logic [1:0]        code1,
  input  logic [1:0]        code2,
  output logic [ADDR_W-1:0] addr
);

  logic [4:0] low_part;

  assign low_part = strap_digit(code2) * 5'd9
                  + strap_digit(code1) * 5'd3
                  + strap_digit(code0);

  always_ff @(posedge clk) begin
    if (rst) addr <= {ADDR_TOP, 5'd0};
    else     addr <= {ADDR_TOP, low_part};
  end

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int         DEPTH    = 8,
  parameter int         W        = 8,
  parameter int         AW       = $clog2(DEPTH),
  parameter logic [7:0] INIT0    = 8'h10,
  parameter int         FLAG_BIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          flag0
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == 0) ? W'(INIT0) : '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign flag0 = mem[0][FLAG_BIT];

endmodule

// File: rtl/smbus_alert_slave.sv
module smbus_alert_slave #(
  parameter int         NUM_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         MWEN_BIT    = 4,
  parameter logic [7:0] REG0_INIT   = 8'h10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [1:0] strap0,
  input  logic [1:0] strap1,
  input  logic [1:0] strap2,
  input  logic       alert_req,
  output logic       alert_pull
);

  import smb_pkg::*;

  localparam int PTR_W  = $clog2(NUM_REGS);
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;

  bus_st_t          st;
  rx_kind_t         kind, nxt_kind;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] sh;
  logic             ack_ph;
  logic             go_tx;
  logic             ara_mode;
  logic             mack_ok;
  logic [PTR_W-1:0] ptr;
  logic             req_d;

  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;
  logic              mwen;

  logic [BYTE_W-1:0] byte_in;
  logic [BYTE_W-1:0] tx_byte;
  logic              bus_idle;

  smb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_strap_addr u_strap (
    .clk   (clk),
    .rst   (rst),
    .code0 (strap0),
    .code1 (strap1),
    .code2 (strap2),
    .addr  (own_addr)
  );

  smb_regfile #(
    .DEPTH    (NUM_REGS),
    .W        (BYTE_W),
    .AW       (PTR_W),
    .INIT0    (REG0_INIT),
    .FLAG_BIT (MWEN_BIT)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (ptr),
    .rdata (rd_data),
    .flag0 (mwen)
  );

  assign byte_in  = {sh[BYTE_W-2:0], sda_s};
  assign tx_byte  = ara_mode ? {own_addr, 1'b1} : rd_data;
  assign bus_idle = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      st         <= ST_IDLE;
      kind       <= RK_ADDR;
      nxt_kind   <= RK_ADDR;
      cnt        <= '0;
      sh         <= '0;
      ack_ph     <= 1'b0;
      go_tx      <= 1'b0;
      ara_mode   <= 1'b0;
      mack_ok    <= 1'b0;
      ptr        <= '0;
      wr_addr    <= '0;
      wr_data    <= '0;
      sda_pull   <= 1'b0;
      alert_pull <= 1'b0;
      req_d      <= 1'b0;
    end else begin
      req_d <= alert_req;
      if (start_det) begin
        st       <= ST_RX;
        kind     <= RK_ADDR;
        cnt      <= '0;
        ara_mode <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= byte_in;
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                st     <= ST_ACK;
                ack_ph <= 1'b0;
                go_tx  <= 1'b0;
                case (kind)
                  RK_ADDR: begin
                    nxt_kind <= RK_CMD;
                    if (byte_in[BYTE_W-1:1] == own_addr) begin
                      go_tx <= byte_in[0];
                    end else if (byte_in[BYTE_W-1:1] == MASS_ADDR && !byte_in[0] && mwen) begin
                      go_tx <= 1'b0;
                    end else if (byte_in[BYTE_W-1:1] == ARA_ADDR && byte_in[0] && alert_pull) begin
                      go_tx    <= 1'b1;
                      ara_mode <= 1'b1;
                    end else begin
                      st <= ST_WAIT;
                    end
                  end
                  RK_CMD: begin
                    ptr      <= byte_in[PTR_W-1:0];
                    nxt_kind <= RK_DATA;
                  end
                  RK_DATA: begin
                    wr_en    <= 1'b1;
                    wr_addr  <= ptr;
                    wr_data  <= byte_in;
                    nxt_kind <= RK_SPILL;
                  end
                  default: nxt_kind <= RK_SPILL;
                endcase
              end
            end
          end

          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_ph) begin
                sda_pull <= 1'b1;
                ack_ph   <= 1'b1;
              end else begin
                cnt <= '0;
                if (go_tx) begin
                  sh       <= tx_byte;
                  sda_pull <= ~tx_byte[BYTE_W-1];
                  st       <= ST_TX;
                end else begin
                  sda_pull <= 1'b0;
                  kind     <= nxt_kind;
                  st       <= ST_RX;
                end
              end
            end
          end

          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (ara_mode && !sda_pull && !sda_s) begin
                st <= ST_WAIT;
              end
            end else if (scl_fall) begin
              if (cnt == ALL_BITS) begin
                sda_pull <= 1'b0;
                st       <= ST_MACK;
                if (ara_mode) alert_pull <= 1'b0;
              end else begin
                sh       <= {sh[BYTE_W-2:0], 1'b0};
                sda_pull <= ~sh[BYTE_W-2];
              end
            end
          end

          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_ok && !ara_mode) begin
                cnt      <= '0;
                sh       <= tx_byte;
                sda_pull <= ~tx_byte[BYTE_W-1];
                st       <= ST_TX;
              end else begin
                st <= ST_WAIT;
              end
            end
          end

          default: ;
        endcase
      end
      if (alert_req && !req_d) alert_pull <= 1'b1;
    end
  end

endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull,
  input logic alert_pull,
  input logic alert_req,
  input logic bus_idle
);

  // R10
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> !$past(scl_s));

  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_pull);

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> bus_idle);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> !sda_pull);

  // R9
  alert_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_pull) |-> $past(alert_req));

endmodule

bind smbus_alert_slave smb_alert_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .sda_pull   (sda_pull),
  .alert_pull (alert_pull),
  .alert_req  (alert_req),
  .bus_idle   (bus_idle)
);

// File: tb/sim_smbus_alert_slave.sv
module sim_smbus_alert_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam logic [6:0] MASS = 7'b1011111;
  localparam logic [6:0] ARA  = 7'b0001100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic alert_req = 1'b0;
  logic [1:0] s0 = 2'd0, s1 = 2'd0, s2 = 2'd0;
  logic sda_pull, alert_pull;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int viol   = 0;
  logic done = 1'b0;
  logic prev_pull = 1'b0;

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_alert_slave u0 (
    .clk        (clk),
    .rst        (rst),
    .scl_in     (scl_m),
    .sda_in     (sda_line),
    .sda_pull   (sda_pull),
    .strap0     (s0),
    .strap1     (s1),
    .strap2     (s2),
    .alert_req  (alert_req),
    .alert_pull (alert_pull)
  );

  // R10 monitor: slave output must never move while SCL is high
  always @(negedge clk) begin
    if (!rst && (sda_pull !== prev_pull) && scl_m) viol = viol + 1;
    prev_pull = sda_pull;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] own_of(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
    int d0, d1, d2;
    d0 = (a == 2'd3) ? 2 : int'(a);
    d1 = (b == 2'd3) ? 2 : int'(b);
    d2 = (c == 2'd3) ? 2 : int'(c);
    return {2'b10, 5'(d2 * 9 + d1 * 3 + d0)};
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic mb, output logic rb);
    sda_m = mb;
    waitc(Q);
    scl_m = 1'b1;
    waitc(Q/2);
    rb = sda_line;
    waitc(Q/2);
    scl_m = 1'b0;
    waitc(2);
  endtask

  task automatic start_c;
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic stop_c;
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic [7:0] mb, input logic mack,
                           output logic [7:0] v, output logic ninth);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(mb[i], r);
      v[i] = r;
    end
    bit_xfer(~mack, ninth);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] cmd,
                           input logic [7:0] d, output logic [2:0] ak);
    logic k2, k1, k0;
    start_c;
    send_byte({a, 1'b0}, k2);
    send_byte(cmd, k1);
    send_byte(d, k0);
    stop_c;
    ak = {k2, k1, k0};
  endtask

  task automatic read_reg(input logic [6:0] a, input logic [7:0] cmd,
                          output logic [7:0] v, output logic [2:0] ak, output logic ninth);
    logic k2, k1, k0;
    start_c;
    send_byte({a, 1'b0}, k2);
    send_byte(cmd, k1);
    start_c;
    send_byte({a, 1'b1}, k0);
    recv_byte(8'hFF, 1'b0, v, ninth);
    stop_c;
    ak = {k2, k1, k0};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b1, b2, b3;
    logic [2:0] ak;
    logic ninth, k, r;
    logic [6:0] own;

    waitc(10);
    // R11 reset state
    check("R11 sda_pull in reset", int'(sda_pull), 0);
    check("R11 alert_pull in reset", int'(alert_pull), 0);
    rst = 1'b0;
    waitc(4);
    check("R11 sda_pull after reset", int'(sda_pull), 0);
    check("R11 alert_pull after reset", int'(alert_pull), 0);

    // R7 reset contents, R4 read path
    own = own_of(s0, s1, s2);
    for (int i = 0; i < 8; i++) begin
      read_reg(own, 8'(i), v, ak, ninth);
      check("R4 read acks", int'(ak), 7);
      check("R7 reset value", int'(v), (i == 0) ? 8'h10 : 8'h00);
      check("R4 ninth released", int'(ninth), 1);
    end

    // R2 R3 R10 sweep over all 27 strap settings
    for (int c2 = 0; c2 < 3; c2++) begin
      for (int c1 = 0; c1 < 3; c1++) begin
        for (int c0 = 0; c0 < 3; c0++) begin
          int idx;
          logic [7:0] d;
          logic [7:0] rr;
          logic [6:0] wrong;
          idx = c2 * 9 + c1 * 3 + c0;
          s0 = 2'(c0); s1 = 2'(c1); s2 = 2'(c2);
          waitc(4);
          own   = own_of(s0, s1, s2);
          wrong = {2'b10, 5'((idx + 1) % 27)};
          rr    = 8'((idx % 7) + 1);
          d     = 8'(idx * 37 + 11);
          write_reg(own, rr, d, ak);
          check("R2 R3 write acks", int'(ak), 7);
          write_reg(wrong, rr, ~d, ak);
          check("R10 foreign address nack", int'(ak), 0);
          read_reg(own, rr, v, ak, ninth);
          check("R2 R4 read acks", int'(ak), 7);
          check("R3 R10 stored value", int'(v), int'(d));
        end
      end
    end

    // R2 strap code 3 behaves as high
    s0 = 2'd3; s1 = 2'd3; s2 = 2'd3;
    waitc(4);
    write_reg(7'b1011010, 8'd4, 8'hC3, ak);
    check("R2 code3 write acks", int'(ak), 7);
    read_reg(7'b1011010, 8'd4, v, ak, ninth);
    check("R2 code3 readback", int'(v), 8'hC3);

    s0 = 2'd1; s1 = 2'd2; s2 = 2'd0;
    waitc(4);
    own = own_of(s0, s1, s2);

    // R3 upper command bits ignored
    write_reg(own, 8'hF9, 8'h6B, ak);
    read_reg(own, 8'h01, v, ak, ninth);
    check("R3 pointer from low bits", int'(v), 8'h6B);

    // R6 write word, R5 read word
    start_c;
    send_byte({own, 1'b0}, k); check("R6 addr ack", int'(k), 1);
    send_byte(8'd5, k);        check("R6 cmd ack", int'(k), 1);
    send_byte(8'hA5, k);       check("R6 first data ack", int'(k), 1);
    send_byte(8'h3C, k);       check("R6 second data ack", int'(k), 1);
    stop_c;
    start_c;
    send_byte({own, 1'b0}, k);
    send_byte(8'd5, k);
    start_c;
    send_byte({own, 1'b1}, k);
    recv_byte(8'hFF, 1'b1, b1, ninth);
    recv_byte(8'hFF, 1'b0, b2, ninth);
    recv_byte(8'hFF, 1'b0, b3, ninth);
    stop_c;
    check("R6 first byte kept", int'(b1), 8'hA5);
    check("R5 second byte repeats", int'(b2), 8'hA5);
    check("R5 released after nack", int'(b3), 8'hFF);

    // R7 broadcast write
    write_reg(MASS, 8'd3, 8'h77, ak);
    check("R7 broadcast acks", int'(ak), 7);
    read_reg(own, 8'd3, v, ak, ninth);
    check("R7 broadcast stored", int'(v), 8'h77);
    start_c;
    send_byte({MASS, 1'b1}, k);
    stop_c;
    check("R7 broadcast read nack", int'(k), 0);
    write_reg(own, 8'd0, 8'h00, ak);
    write_reg(MASS, 8'd3, 8'h11, ak);
    check("R7 disabled broadcast nack", int'(ak), 0);
    read_reg(own, 8'd3, v, ak, ninth);
    check("R7 disabled broadcast no write", int'(v), 8'h77);
    write_reg(own, 8'd0, 8'h10, ak);

    // R1 START inside address byte
    start_c;
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, r);
    write_reg(own, 8'd2, 8'h21, ak);
    check("R1 restart after partial addr", int'(ak), 7);
    // R1 START inside data byte
    start_c;
    send_byte({own, 1'b0}, k);
    send_byte(8'd2, k);
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, r);
    start_c;
    send_byte({own, 1'b0}, k);
    send_byte(8'd6, k);
    send_byte(8'h66, k);
    stop_c;
    read_reg(own, 8'd2, v, ak, ninth);
    check("R1 partial data dropped", int'(v), 8'h21);
    read_reg(own, 8'd6, v, ak, ninth);
    check("R1 transfer after restart", int'(v), 8'h66);

    // R8 alert response
    start_c;
    send_byte({ARA, 1'b1}, k);
    stop_c;
    check("R8 no alert nack", int'(k), 0);
    alert_req = 1'b1; waitc(1); alert_req = 1'b0;
    waitc(3);
    check("R9 alert set", int'(alert_pull), 1);
    start_c;
    send_byte({ARA, 1'b0}, k);
    stop_c;
    check("R8 write to ARA nack", int'(k), 0);
    // R9 arbitration loss against a lower address
    start_c;
    send_byte({ARA, 1'b1}, k);
    check("R8 ack while alert", int'(k), 1);
    recv_byte(8'h15, 1'b0, v, ninth);
    stop_c;
    check("R9 competitor wins bus", int'(v), 8'h15);
    check("R9 alert kept after loss", int'(alert_pull), 1);
    start_c;
    send_byte({ARA, 1'b1}, k);
    check("R8 ack retry", int'(k), 1);
    recv_byte(8'hFF, 1'b0, v, ninth);
    stop_c;
    check("R8 own address sent", int'(v), int'({own, 1'b1}));
    check("R8 alert released", int'(alert_pull), 0);

    check("R10 sda moves only with scl low", viol, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule